// File: doc/BRIEF.md
# Descriptor Ring Poll Interval Timer

This block is a programmable periodic timer that raises a single-tick poll request. A DMA engine uses that request to look at its descriptor rings again. The timer runs on a clock at twice the crystal frequency, so one tick is half a crystal period. Two 16-bit registers control it. The interval register holds the two's complement of the wanted delay: bit 16 is taken as one, and bits 3:0 are forced to zero when the value is loaded. The up-counter starts from that loaded value. When it passes 0xFFFF it reloads and fires the request.

Software reads and writes both registers over a simple word-wide register bus. Access is granted only while the controller's stop or suspend control input is high, and writes at any other time are dropped. A run input enables counting. A restart input, or a rising edge on run, reloads the counter from the interval register. The all-zero reset value gives the longest period, 65536 ticks.

Top module: `poll_interval_timer`

## Requirements
- R1: A synchronous active-low reset clears the interval register and the counter to zero and holds poll_req low.
- R2: While run stays high, poll_req pulses once every 65536 − M ticks, where M is the interval register with bits 3:0 cleared. The first pulse comes 65536 − M ticks after the tick in which the counter was loaded.
- R3: Bits 3:0 of the interval register have no effect on the period. The values 0xFFF0 and 0xFFFF both give 16 ticks.
- R4: An interval value of 0x0000 gives a period of 65536 ticks.
- R5: poll_req is high for exactly one tick. The counter reloads in the same tick, so the next interval follows with no gap.
- R6: While run is low and neither restart nor a counter write occurs, the counter keeps its value and poll_req stays low.
- R7: In any tick where restart is high, or run is high after having been low, the counter loads the masked interval value.
- R8: A write is accepted only when stop or susp is high. Writes made with both low leave both registers unchanged.
- R9: reg_rdata shows the selected register, zero-extended to 32 bits, only when reg_rd is high and stop or susp is high. At all other times it reads zero. reg_sel = 0 selects the interval register and reg_sel = 1 selects the counter.
- R10: An accepted counter write replaces the running count at once and takes priority over loading and counting. Writing 0xFFFD while running gives a pulse 3 ticks after the write tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, two ticks per crystal period |
| rst_n | input | 1 | Synchronous active-low reset |
| stop | input | 1 | Controller stopped, grants register access |
| susp | input | 1 | Controller suspended, grants register access |
| run | input | 1 | Counting enable |
| restart | input | 1 | Reload counter from interval register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = interval register, 1 = counter |
| reg_wdata | input | 32 | Write data, low 16 bits used |
| reg_rdata | output | 32 | Read data, upper 16 bits zero |
| poll_req | output | 1 | One-tick descriptor poll request |

## Verification
A wrong count or a wrong reload value only becomes visible at the ports when the next poll_req arrives. That can be as late as 65536 ticks, unless the counter is read back while access is granted, which shows it on the same tick. For that reason the bench compares poll_req and reg_rdata with a behavioural model on every tick. It also checks pulse spacing from a known load point. A write that slips through the access gate stays hidden until a later read, so each gated write is followed by a read once access is open.

// File: rtl/poll_pkg.sv
// Package: shared widths and register selector encoding for the poll timer.
// Assumes: a 16-bit interval with an implied bit 16 and a 32-bit register bus.
package poll_pkg;
    localparam int POLL_CNT_W   = 16;
    localparam int POLL_BUS_W   = 32;
    localparam int POLL_IGN_LSB = 4;

    typedef enum logic {
        SEL_IVAL = 1'b0,
        SEL_CNT  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/poll_regs.sv
// Module: poll_regs
// Holds the interval register, decodes bus writes and drives the read mux.
// Access goes through only while stop or susp is high. Reserved upper bits
// are dropped on write and read back as zero.
// Assumes: the counter value comes from poll_counter, which owns the count.
module poll_regs
    import poll_pkg::*;
#(
    parameter int CNT_W = POLL_CNT_W,
    parameter int BUS_W = POLL_BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             susp,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_sel,
    input  logic [BUS_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] ival_q,
    output logic             cnt_wr,
    output logic [CNT_W-1:0] cnt_wdata,
    output logic [BUS_W-1:0] reg_rdata
);
    localparam int RES_W = BUS_W - CNT_W;

    logic access;
    logic ival_wr;
    logic unused_res;

    // Register access is open only while the controller is halted
    assign access     = stop | susp;
    assign ival_wr    = reg_wr & access & (reg_sel == SEL_IVAL);
    assign cnt_wr     = reg_wr & access & (reg_sel == SEL_CNT);
    assign cnt_wdata  = reg_wdata[CNT_W-1:0];
    assign unused_res = ^reg_wdata[BUS_W-1:CNT_W];

    // Interval register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q <= '0;
        end else if (ival_wr) begin
            ival_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // Read mux, zero-extended, gated by strobe and access
    always_comb begin
        reg_rdata = '0;
        if (reg_rd && access) begin
            reg_rdata = {{RES_W{1'b0}}, (reg_sel == SEL_CNT) ? cnt_q : ival_q};
        end
    end

    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !stop && !susp) |=> (ival_q == $past(ival_q))); // R8
endmodule

// File: rtl/poll_counter.sv
// Module: poll_counter
// Up-counter from the masked interval value. Passing all-ones reloads it and
// fires a one-tick poll request. A software write has top priority, then
// restart or run start, then counting.
// Assumes: one tick per half crystal period; ival comes from poll_regs.
module poll_counter
    import poll_pkg::*;
#(
    parameter int CNT_W   = POLL_CNT_W,
    parameter int IGN_LSB = POLL_IGN_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] ival,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             poll_req
);
    logic [CNT_W-1:0] load_val;
    logic             run_d;
    logic             start_load;
    logic             wrap;

    // Load value: low bits masked when the parameter asks for it
    generate
        if (IGN_LSB == 0) begin : g_nomask
            assign load_val = ival;
        end else begin : g_mask
            logic unused_low;
            assign unused_low = ^ival[IGN_LSB-1:0];
            assign load_val   = {ival[CNT_W-1:IGN_LSB], {IGN_LSB{1'b0}}};
        end
    endgenerate

    // Reload triggers and overflow detect
    assign start_load = restart | (run & ~run_d);
    assign wrap       = &cnt_q;

    // Count, reload and poll pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            poll_req <= 1'b0;
            run_d    <= 1'b0;
        end else begin
            run_d    <= run;
            poll_req <= 1'b0;
            if (cnt_wr) begin
                cnt_q <= cnt_wdata;
            end else if (start_load) begin
                cnt_q <= load_val;
            end else if (run) begin
                if (wrap) begin
                    cnt_q    <= load_val;
                    poll_req <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |=> !poll_req); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart && !cnt_wr) |=> (cnt_q == $past(cnt_q) && !poll_req)); // R6
    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !cnt_wr) |=> (cnt_q[IGN_LSB-1:0] == '0)); // R7
    AST_WRAP_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !cnt_wr && $past(run) && cnt_q == '1) |=> poll_req); // R2
    AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(cnt_wdata))); // R10
endmodule

// File: rtl/poll_interval_timer.sv
// Module: poll_interval_timer
// Top of the descriptor ring poll timer: register block plus interval counter.
// Assumes: clk runs at twice the crystal rate; the bus is single-cycle strobes.
module poll_interval_timer
    import poll_pkg::*;
#(
    parameter int CNT_W   = POLL_CNT_W,
    parameter int BUS_W   = POLL_BUS_W,
    parameter int IGN_LSB = POLL_IGN_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             susp,
    input  logic             run,
    input  logic             restart,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_sel,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    output logic             poll_req
);
    logic [CNT_W-1:0] ival_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_wdata;
    logic             cnt_wr;

    poll_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .stop(stop), .susp(susp),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cnt_q(cnt_q), .ival_q(ival_q),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .reg_rdata(reg_rdata)
    );

    poll_counter #(.CNT_W(CNT_W), .IGN_LSB(IGN_LSB)) u_counter (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .ival(ival_q), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cnt_q(cnt_q), .poll_req(poll_req)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !poll_req); // R1
endmodule

// File: tb/poll_interval_timer_bench.sv
module poll_interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop = 1'b0, susp = 1'b0, run = 1'b0, restart = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        poll_req;

    int tests = 0, fails = 0, tick = 0;
    string cur_req = "R1";

    // behavioural reference model state
    int m_ival = 0, m_cnt = 0, m_req = 0, m_run_d = 0;

    always #5 clk = ~clk;

    poll_interval_timer u_poll_interval_timer (
        .clk(clk), .rst_n(rst_n), .stop(stop), .susp(susp), .run(run),
        .restart(restart), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .poll_req(poll_req)
    );

    always @(posedge clk) begin
        int acc, load, nc, nr;
        tick++;
        if (!rst_n) begin
            m_ival = 0; m_cnt = 0; m_req = 0; m_run_d = 0;
        end else begin
            acc  = (stop || susp) ? 1 : 0;
            load = (m_ival / 16) * 16;
            nc = m_cnt; nr = 0;
            if (reg_wr && acc && reg_sel) nc = reg_wdata % 65536;
            else if (restart || (run && !m_run_d)) nc = load;
            else if (run) begin
                if (m_cnt == 65535) begin nc = load; nr = 1; end
                else nc = m_cnt + 1;
            end
            if (reg_wr && acc && !reg_sel) m_ival = reg_wdata % 65536;
            m_cnt = nc; m_req = nr; m_run_d = run ? 1 : 0;
        end
    end

    task automatic check(string req, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-tick comparison against the model, away from the edge
    always @(negedge clk) begin
        int exp_rd;
        #1;
        if (rst_n) begin
            exp_rd = (reg_rd && (stop || susp)) ? (reg_sel ? m_cnt : m_ival) : 0;
            check(cur_req, int'(poll_req), m_req, "poll_req vs model");
            check(cur_req, int'(reg_rdata), exp_rd, "reg_rdata vs model");
        end
    end

    task automatic bus_write(logic sel, logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_read(logic sel, output int v);
        @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
        #2 v = int'(reg_rdata);
        @(negedge clk); reg_rd = 1'b0;
    endtask

    // waits for the next pulse; returns the edge index that raised it
    task automatic wait_pulse(output int t);
        int guard = 0;
        t = -1;
        while (guard < 70000) begin
            @(negedge clk); #2;
            if (poll_req) begin t = tick; break; end
            guard++;
        end
    endtask

    // drive restart for one tick; returns the index of the loading edge
    task automatic pulse_restart(output int t0);
        @(negedge clk); restart = 1'b1; t0 = tick + 1;
        @(negedge clk); restart = 1'b0;
    endtask

    initial begin
        #(10 * 190000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int v, t0, t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        stop = 1'b1;
        bus_read(1'b0, v); check("R1", v, 0, "interval after reset");
        bus_read(1'b1, v); check("R1", v, 0, "counter after reset");
        check("R1", int'(poll_req), 0, "poll_req after reset");
        // R9: read without access is zero
        cur_req = "R9";
        stop = 1'b0;
        @(negedge clk); reg_rd = 1'b1; reg_sel = 1'b0; #2
        check("R9", int'(reg_rdata), 0, "read without access");
        @(negedge clk); reg_rd = 1'b0;
        // R8: gated write ignored
        cur_req = "R8";
        bus_write(1'b0, 32'h0000_FFF0);
        stop = 1'b1;
        bus_read(1'b0, v); check("R8", v, 0, "interval after blocked write");
        // R8 via susp, R9 upper bits zero
        stop = 1'b0; susp = 1'b1;
        bus_write(1'b0, 32'hABCD_FFF0);
        bus_read(1'b0, v); check("R9", v, 32'h0000_FFF0, "interval readback upper zero");
        susp = 1'b0;
        // R2/R7: run rising loads, period 16
        cur_req = "R2";
        @(negedge clk); run = 1'b1; t0 = tick + 1;
        wait_pulse(t1); check("R2", t1 - t0, 16, "first period 0xFFF0");
        wait_pulse(t2); check("R5", t2 - t1, 16, "back-to-back period");
        @(negedge clk); #2 check("R5", int'(poll_req), 0, "pulse width one");
        // R6: hold while run low
        cur_req = "R6";
        @(negedge clk); run = 1'b0; stop = 1'b1;
        bus_read(1'b1, t1);
        repeat (10) @(negedge clk);
        bus_read(1'b1, t2); check("R6", t2, t1, "counter held");
        check("R6", int'(poll_req), 0, "no pulse while idle");
        // R3: low nibble ignored
        cur_req = "R3";
        bus_write(1'b0, 32'h0000_FFFF);
        stop = 1'b0;
        @(negedge clk); run = 1'b1; t0 = tick + 1;
        wait_pulse(t1); check("R3", t1 - t0, 16, "0xFFFF masks to 16");
        stop = 1'b1; bus_write(1'b0, 32'h0000_FFE7); stop = 1'b0;
        cur_req = "R7";
        pulse_restart(t0);
        wait_pulse(t1); check("R3", t1 - t0, 32, "0xFFE7 masks to 32");
        check("R7", t1 - t0, 32, "restart reload");
        // R10: counter write while running
        cur_req = "R10";
        @(negedge clk); stop = 1'b1; reg_wr = 1'b1; reg_sel = 1'b1;
        reg_wdata = 32'h0000_FFFD; t0 = tick + 1;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0; stop = 1'b0;
        wait_pulse(t1); check("R10", t1 - t0, 3, "direct counter write");
        // R4: default value longest period
        cur_req = "R4";
        stop = 1'b1; bus_write(1'b0, 32'h0); stop = 1'b0;
        pulse_restart(t0);
        wait_pulse(t1); check("R4", t1 - t0, 65536, "zero interval period");
        @(negedge clk); run = 1'b0;
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule